// File: doc/BRIEF.md
# Reloadable Dual-Mode Interrupt Down-Counter

This block is the interrupt timer of a cartridge bank controller that sits on an 8-bit CPU bus. Software programs it through four write-only registers: an 8-bit reload value, a reload request that also picks the count source, and two commands that turn the interrupt off or on. Every command write also clears a raised interrupt. The counter steps down once per tick. The tick comes from a per-CPU-cycle pulse or from a per-scanline pulse, and the stored mode bit chooses which one.

When a tick leaves the counter at zero while interrupts are on, a short delay starts. The delay counts CPU-cycle pulses, whatever the mode. When it runs out, a level interrupt is raised and held until software clears it. A requested reload takes effect on the next tick. If the reload value is nonzero, the loaded count is forced odd. When the count reaches zero it wraps back to the reload value on the next tick.

Top module: `irqc_top`

## Requirements
- R1: A write is accepted only when both `bus_wr` and `bus_cs` are high. The register is chosen by address bits 15..13 and bit 0 alone. Bits 15..13 = 110 with bit 0 = 0 selects the reload value, 110 with bit 0 = 1 the reload request, 111 with bit 0 = 0 interrupt-off and 111 with bit 0 = 1 interrupt-on. Other address bits are mirrors, and any other value of bits 15..13 is ignored.
- R2: A write to the reload-value register stores `bus_data` and has no other effect. In particular it does not clear a raised interrupt.
- R3: A write to the reload-request register sets a pending-reload flag and stores `bus_data[0]` as the mode. Mode 1 counts `cpu_tick` pulses and mode 0 counts `line_tick` pulses. The unselected source never moves the counter.
- R4: A tick with a reload pending loads the reload value and clears the flag. If the value is nonzero, bit 0 of the loaded count is forced to 1. A zero value loads 0.
- R5: A tick with no reload pending loads the reload value if the count is zero, and otherwise decrements the count by one.
- R6: If the count is zero after a tick and interrupts are on, a delay of 4 is started. The delay decrements on every `cpu_tick` in either mode. `irq` rises after the 4th `cpu_tick` that follows the starting tick.
- R7: A new zero-with-enable event while a delay is running restarts the delay at 4.
- R8: A write to interrupt-off clears the enable and a write to interrupt-on sets it. Both clear `irq`. With the enable clear, reaching zero starts no delay.
- R9: If a register write and a tick arrive in the same cycle, the write is applied first. The tick then uses the new mode, the new reload value and the new reload flag.
- R10: Reset clears the enable, the reload flag, the counter, the reload value, the delay and `irq`, and selects mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per bus write |
| bus_cs | input | 1 | Chip select for the upper half of the address space |
| bus_addr | input | 16 | CPU address |
| bus_data | input | 8 | CPU write data |
| cpu_tick | input | 1 | One pulse per qualifying CPU cycle |
| line_tick | input | 1 | One pulse per scanline |
| irq | output | 1 | Active-high interrupt level |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe, that the tick inputs are single-cycle pulses in the clock domain, and that nothing happens until the internal reset release, which takes two clocks. The bench drives every input on the falling edge, holds each strobe and tick for exactly one cycle and waits out the reset release before the first write. The write-first case drives a write and a tick in the same cycle. It does so on purpose, and only through a dedicated task.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    MODE_LINE = 1'b0,
    MODE_CPU  = 1'b1
  } tick_mode_e;

  typedef struct packed {
    logic set_value;
    logic req_reload;
    logic irq_off;
    logic irq_on;
  } reg_wr_t;

  localparam logic [2:0] PAGE_COUNT = 3'b110;
  localparam logic [2:0] PAGE_IRQ   = 3'b111;

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_stb,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  output reg_wr_t           wr
);

  logic [2:0] page;
  logic       sub;
  logic       hit;
  logic       unused_mirror_bits;

  assign page = addr[ADDR_W-1 -: 3];
  assign sub  = addr[0];
  assign hit  = wr_stb & cs;
  assign unused_mirror_bits = ^addr[ADDR_W-4:1];

  always_comb begin
    wr = '0;
    if (hit) begin
      unique case (page)
        PAGE_COUNT: begin
          wr.set_value  = ~sub;
          wr.req_reload = sub;
        end
        PAGE_IRQ: begin
          wr.irq_off = ~sub;
          wr.irq_on  = sub;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_wr_t          wr,
  input  logic [CNT_W-1:0] data,
  output logic [CNT_W-1:0] value_eff,
  output tick_mode_e       mode_eff,
  output logic             en_eff
);

  logic [CNT_W-1:0] value_q, value_d;
  tick_mode_e       mode_q, mode_d;
  logic             en_q, en_d;

  always_comb begin
    value_d = value_q;
    mode_d  = mode_q;
    en_d    = en_q;
    if (wr.set_value)  value_d = data;
    if (wr.req_reload) mode_d  = tick_mode_e'(data[0]);
    if (wr.irq_off)    en_d    = 1'b0;
    if (wr.irq_on)     en_d    = 1'b1;
  end

  // Write-first view for the counter in the same cycle
  assign value_eff = value_d;
  assign mode_eff  = mode_d;
  assign en_eff    = en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      mode_q  <= MODE_LINE;
      en_q    <= 1'b0;
    end else begin
      value_q <= value_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
    end
  end

  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr.set_value |=> $stable(value_q)); // R2
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr.irq_off |=> !en_q); // R8
  AST_EN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    wr.irq_on |=> en_q); // R8

endmodule

// File: rtl/irqc_counter.sv
module irqc_counter
  import irqc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_tick,
  input  logic             line_tick,
  input  logic             req_reload,
  input  logic [CNT_W-1:0] value_eff,
  input  tick_mode_e       mode_eff,
  input  logic             en_eff,
  output logic             zero_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             reload_q, reload_d;
  logic             reload_eff;
  logic             tick;
  logic [CNT_W-1:0] odd_mask;

  assign tick       = (mode_eff == MODE_CPU) ? cpu_tick : line_tick;
  assign reload_eff = reload_q | req_reload;
  assign odd_mask   = {{(CNT_W-1){1'b0}}, (value_eff != '0)};

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_eff;
    if (tick) begin
      reload_d = 1'b0;
      if (reload_eff)        cnt_d = value_eff | odd_mask;
      else if (cnt_q == '0)  cnt_d = value_eff;
      else                   cnt_d = cnt_q - CNT_W'(1);
    end
  end

  assign zero_evt = tick & en_eff & (cnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R3
  AST_RELOAD_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_eff && value_eff != '0) |=> cnt_q[0]); // R4
  AST_RELOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !req_reload) |=> !reload_q); // R4
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload_eff && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5

endmodule

// File: rtl/irqc_delay.sv
module irqc_delay #(
  parameter int DELAY_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_tick,
  input  logic start,
  input  logic ack,
  output logic irq
);

  localparam int DLY_W = $clog2(DELAY_TICKS + 1);

  logic [DLY_W-1:0] dly_q, dly_d;
  logic             irq_q, irq_d;
  logic             expire;

  assign expire = cpu_tick & (dly_q == DLY_W'(1));

  always_comb begin
    dly_d = dly_q;
    if (start)                         dly_d = DLY_W'(DELAY_TICKS);
    else if (cpu_tick && dly_q != '0)  dly_d = dly_q - DLY_W'(1);
    irq_d = expire | (irq_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      irq_q <= 1'b0;
    end else begin
      dly_q <= dly_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dly_q == DLY_W'(DELAY_TICKS))); // R7
  AST_DLY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q <= DLY_W'(DELAY_TICKS)); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !expire) |=> !irq_q); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !irq_q); // R8

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 8,
  parameter int DELAY_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_cs,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_data,
  input  logic              cpu_tick,
  input  logic              line_tick,
  output logic              irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  reg_wr_t          wr;
  logic [CNT_W-1:0] value_eff;
  tick_mode_e       mode_eff;
  logic             en_eff;
  logic             zero_evt;
  logic             ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  irqc_regdec #(.ADDR_W(ADDR_W)) regdec_i (
    .wr_stb (bus_wr),
    .cs     (bus_cs),
    .addr   (bus_addr),
    .wr     (wr)
  );

  irqc_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr        (wr),
    .data      (bus_data),
    .value_eff (value_eff),
    .mode_eff  (mode_eff),
    .en_eff    (en_eff)
  );

  irqc_counter #(.CNT_W(CNT_W)) counter_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cpu_tick   (cpu_tick),
    .line_tick  (line_tick),
    .req_reload (wr.req_reload),
    .value_eff  (value_eff),
    .mode_eff   (mode_eff),
    .en_eff     (en_eff),
    .zero_evt   (zero_evt)
  );

  assign ack = wr.irq_off | wr.irq_on;

  irqc_delay #(.DELAY_TICKS(DELAY_TICKS)) delay_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cpu_tick (cpu_tick),
    .start    (zero_evt),
    .ack      (ack),
    .irq      (irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_int) |-> !irq); // R10

endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_cs;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data;
  logic        cpu_tick;
  logic        line_tick;
  logic        irq;

  int n_checks;
  int n_fail;
  int cycles;

  irqc_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_cs    (bus_cs),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .cpu_tick  (cpu_tick),
    .line_tick (line_tick),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual irq=%0b expected irq=%0b", req, act, exp);
    end
  endtask

  // One cycle with the given inputs, returns at the following falling edge
  task automatic cyc(input logic ct, input logic lt, input logic wr, input logic cs,
                     input logic [15:0] a, input logic [7:0] d);
    cpu_tick = ct; line_tick = lt; bus_wr = wr; bus_cs = cs; bus_addr = a; bus_data = d;
    @(negedge clk);
    cpu_tick = 1'b0; line_tick = 1'b0; bus_wr = 1'b0; bus_cs = 1'b0;
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, a, d);
  endtask

  task automatic cpu_ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic line_ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_cs = 1'b0; bus_addr = '0; bus_data = '0;
    cpu_tick = 1'b0; line_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(irq, 1'b0, "R10 irq after reset");
    wr_reg(16'hC000, 8'h00);
    wr_reg(16'hC001, 8'h00);
    line_ticks(1);
    cpu_ticks(5);
    check(irq, 1'b0, "R10 enable clear after reset");
  endtask

  task automatic t_cpu_mode();
    do_reset();
    wr_reg(16'hC000, 8'h08);
    wr_reg(16'hE001, 8'h00);
    wr_reg(16'hC001, 8'h01);
    line_ticks(2);
    cpu_ticks(13);
    check(irq, 1'b0, "R4 forced odd load delays zero");
    cpu_ticks(1);
    check(irq, 1'b1, "R6 irq after 4 cpu ticks");
    wr_reg(16'hE000, 8'h00);
    check(irq, 1'b0, "R8 interrupt-off clears irq");
    cpu_ticks(20);
    check(irq, 1'b0, "R8 disabled zero starts no delay");
  endtask

  task automatic t_line_mode();
    do_reset();
    wr_reg(16'hDFFE, 8'h02);
    wr_reg(16'hC001, 8'h00);
    wr_reg(16'hFFFF, 8'h00);
    line_ticks(3);
    cpu_ticks(5);
    check(irq, 1'b0, "R3 cpu ticks ignored in line mode");
    line_ticks(1);
    cpu_ticks(3);
    check(irq, 1'b0, "R6 delay not yet expired");
    cpu_ticks(1);
    check(irq, 1'b1, "R6 irq after 4th cpu tick, mirror R1");
    wr_reg(16'hA000, 8'h00);
    check(irq, 1'b1, "R1 write outside pages ignored");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'hE000, 8'h00);
    check(irq, 1'b1, "R1 write without chip select ignored");
    wr_reg(16'hE001, 8'h00);
    check(irq, 1'b0, "R8 interrupt-on clears irq");
  endtask

  task automatic t_zero_value();
    do_reset();
    wr_reg(16'hC000, 8'h00);
    wr_reg(16'hC001, 8'h00);
    wr_reg(16'hE001, 8'h00);
    line_ticks(1);
    cpu_ticks(3);
    check(irq, 1'b0, "R4 zero value not yet fired");
    cpu_ticks(1);
    check(irq, 1'b1, "R4 zero value loads zero");
  endtask

  task automatic t_restart();
    do_reset();
    wr_reg(16'hC000, 8'h01);
    wr_reg(16'hC001, 8'h00);
    wr_reg(16'hE001, 8'h00);
    line_ticks(2);
    cpu_ticks(2);
    line_ticks(2);
    cpu_ticks(3);
    check(irq, 1'b0, "R7 delay restarted at 4");
    cpu_ticks(1);
    check(irq, 1'b1, "R5 wrap from zero then R7 fire");
  endtask

  task automatic t_write_first();
    do_reset();
    wr_reg(16'hC000, 8'h04);
    wr_reg(16'hE001, 8'h00);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 16'hC001, 8'h01);
    cpu_ticks(8);
    check(irq, 1'b0, "R9 not yet fired");
    cpu_ticks(1);
    check(irq, 1'b1, "R9 same-cycle write applied first");
    wr_reg(16'hC000, 8'h10);
    check(irq, 1'b1, "R2 value write does not clear irq");
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    cycles = 0;
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_cs = 1'b0; bus_addr = '0; bus_data = '0;
    cpu_tick = 1'b0; line_tick = 1'b0;
    t_reset_state();
    t_cpu_mode();
    t_line_mode();
    t_zero_value();
    t_restart();
    t_write_first();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule